// File: doc/BRIEF.md
# Write-Leveling Calibration Controller

This block is the controller-side sequencer that calibrates strobe timing during DRAM write leveling. Each byte lane has a delay line on its data strobe, and the memory, while in leveling mode, samples its clock with the rising edge of that strobe and returns the sampled level on the lane's data bits. The sequencer steps every lane's delay code upward from zero, one tap at a time. For each trial setting it issues a short series of strobe pulse requests and samples the returned level after each. It stops a lane at the first setting where the returned level has gone from low to high. That setting is the lane's calibrated delay.

Lanes share one timing sequencer but keep their own feedback, vote and search state. A lane that has locked holds its code while slower lanes continue. A lane that runs out of taps is flagged and its code is parked at zero. The feedback bits are asynchronous to the controller's clock, so each one is synchronized through two flops before it is used. A programmable settle interval follows every delay change, so the analog delay line can settle before the next strobe. A majority vote over several samples per setting filters out metastable or noisy readings.

Top module: `wlvl_cal`

## Requirements
- R1: While rst_n is low and after it rises, delay_o and err_o are all zero, and pulse_o and done_o are low until a start is accepted.
- R2: A start_i pulse in the idle state clears every lane's code and error bit, so delay_o reads zero on the next cycle. A start_i that arrives while a calibration is running has no effect on it.
- R3: Lane i's code, occupying delay_o[i*6 +: 6], is searched only from feedback bit fb_i[i]. That bit passes through a two-flop synchronizer before it is sampled, and lanes reach different final codes independently.
- R4: Every trial setting gets exactly 3 strobe pulse requests, each followed by one sample. The setting's verdict is the majority of the 3 samples, so a single wrong reading does not change the result.
- R5: An unfinished lane's code rises by exactly one after a setting whose verdict does not lock it. The lane locks at the first setting whose verdict is 1 after a setting whose verdict was 0.
- R6: A verdict of 1 seen before any verdict of 0, including at code zero, does not lock the lane. The search continues until a 0 and then a later 1 are seen.
- R7: Once a lane has locked, its code stays constant until the next accepted start, while the other lanes keep searching.
- R8: A lane whose setting equal to tap_limit_i ends without a lock sets its err_o bit and its code returns to zero. A lock found exactly at tap_limit_i is valid, and the lane's code never exceeds tap_limit_i during a run.
- R9: pulse_o is high for single cycles only. At least settle_i cycles pass between any change of delay_o and the next pulse_o.
- R10: done_o is high for exactly one cycle once every lane has either locked or failed, and never before. After that no further pulse_o occurs until the next start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin a calibration (accepted only when idle) |
| fb_i | input | NUM_LANES | Leveling feedback per lane, asynchronous |
| tap_limit_i | input | CODE_W | Highest delay code to try |
| settle_i | input | SETTLE_W | Minimum cycles between a delay change and the next strobe |
| pulse_o | output | 1 | One-cycle request to emit a strobe pulse on all lanes |
| delay_o | output | NUM_LANES*CODE_W | Per-lane delay codes, lane i at bits i*CODE_W +: CODE_W |
| err_o | output | NUM_LANES | Per-lane failure flag |
| done_o | output | 1 | One-cycle pulse when all lanes have locked or failed |

## Verification
The assertions assume that tap_limit_i and settle_i are held steady from an accepted start until done_o. They also assume that each lane's feedback depends only on that lane's current delay code, apart from brief disturbances. The bench derives every feedback bit from the observed delay_o through a model of the memory's sampling threshold, with an optional low-to-high-to-low window on lanes that report 1 at small codes. It changes the limit and settle inputs only while the block is idle. Injected noise inverts the feedback for a window short enough to corrupt one vote out of each setting's three, so the majority still holds.

// File: rtl/wlvl_pkg.sv
// Shared types for the write-leveling calibration controller.
package wlvl_pkg;

    // Sequencer phases for one trial setting and the run around it.
    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_SETTLE,
        SQ_PULSE,
        SQ_WAIT,
        SQ_SAMPLE,
        SQ_DECIDE,
        SQ_EVAL,
        SQ_DONE
    } seq_state_e;

endpackage

// File: rtl/wlvl_sync.sv
// Two-flop synchronizer, one chain per bit.
// Assumes each input bit is a level that may change at any time relative to clk.
module wlvl_sync #(
    parameter int WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] sync_q;

    // Capture the asynchronous bits, then re-register them for stability.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= d_i;
            sync_q <= meta_q;
        end
    end

    assign q_o = sync_q;
endmodule

// File: rtl/wlvl_seq.sv
// Shared timing sequencer: settle, then VOTES rounds of pulse/wait/sample,
// then one decide strobe and an evaluation of whether every lane is finished.
// Assumes settle_i is stable during a run and SAMPLE_LAT fits in SETTLE_W bits.
module wlvl_seq
    import wlvl_pkg::*;
#(
    parameter int SETTLE_W   = 8,
    parameter int VOTES      = 3,
    parameter int SAMPLE_LAT = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic                all_fin_i,
    input  logic [SETTLE_W-1:0] settle_i,
    output logic                clr_o,
    output logic                pulse_o,
    output logic                sample_o,
    output logic                decide_o,
    output logic                done_o
);
    localparam int VCNT_W = $clog2(VOTES + 1);
    localparam logic [SETTLE_W-1:0] LAT_LAST = SETTLE_W'(SAMPLE_LAT - 1);
    localparam logic [VCNT_W-1:0]   VOTE_LAST = VCNT_W'(VOTES - 1);

    seq_state_e            state_q;
    logic [SETTLE_W-1:0]   cnt_q;
    logic [VCNT_W-1:0]     vote_q;

    // Advance through the phases of each trial setting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SQ_IDLE;
            cnt_q   <= '0;
            vote_q  <= '0;
        end else begin
            case (state_q)
                SQ_IDLE: begin
                    cnt_q  <= '0;
                    vote_q <= '0;
                    if (start_i) state_q <= SQ_SETTLE;
                end
                SQ_SETTLE: begin
                    if (cnt_q == settle_i) begin
                        cnt_q   <= '0;
                        state_q <= SQ_PULSE;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                SQ_PULSE: state_q <= SQ_WAIT;
                SQ_WAIT: begin
                    if (cnt_q == LAT_LAST) begin
                        cnt_q   <= '0;
                        state_q <= SQ_SAMPLE;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                SQ_SAMPLE: begin
                    if (vote_q == VOTE_LAST) begin
                        vote_q  <= '0;
                        state_q <= SQ_DECIDE;
                    end else begin
                        vote_q  <= vote_q + 1'b1;
                        state_q <= SQ_PULSE;
                    end
                end
                SQ_DECIDE: state_q <= SQ_EVAL;
                SQ_EVAL:   state_q <= all_fin_i ? SQ_DONE : SQ_SETTLE;
                SQ_DONE:   state_q <= SQ_IDLE;
                default:   state_q <= SQ_IDLE;
            endcase
        end
    end

    // Strobes decoded from the current phase.
    assign clr_o    = (state_q == SQ_IDLE) && start_i;
    assign pulse_o  = (state_q == SQ_PULSE);
    assign sample_o = (state_q == SQ_SAMPLE);
    assign decide_o = (state_q == SQ_DECIDE);
    assign done_o   = (state_q == SQ_DONE);
endmodule

// File: rtl/wlvl_lane.sv
// Per-lane search: accumulates votes from the synchronized feedback bit,
// then on each decide strobe either locks, steps the code, or fails.
// Assumes tap_limit_i is stable between clr_i and the end of the run.
module wlvl_lane #(
    parameter int CODE_W = 6,
    parameter int VOTES  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              sample_i,
    input  logic              decide_i,
    input  logic              fb_i,
    input  logic [CODE_W-1:0] tap_limit_i,
    output logic [CODE_W-1:0] code_o,
    output logic              lock_o,
    output logic              err_o
);
    localparam int ONES_W = $clog2(VOTES + 1);

    logic [CODE_W-1:0] code_q;
    logic [ONES_W-1:0] ones_q;
    logic              seen0_q;
    logic              lock_q;
    logic              err_q;
    logic              fin;
    logic              verdict;

    assign fin     = lock_q | err_q;
    assign verdict = (32'(ones_q) * 2) > VOTES;

    // Count votes, then apply the lock / step / fail decision.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            code_q  <= '0;
            ones_q  <= '0;
            seen0_q <= 1'b0;
            lock_q  <= 1'b0;
            err_q   <= 1'b0;
        end else if (!fin) begin
            if (sample_i) begin
                ones_q <= ones_q + ONES_W'(fb_i);
            end
            if (decide_i) begin
                ones_q <= '0;
                if (verdict && seen0_q) begin
                    lock_q <= 1'b1;
                end else begin
                    if (!verdict) seen0_q <= 1'b1;
                    if (code_q == tap_limit_i) begin
                        err_q  <= 1'b1;
                        code_q <= '0;
                    end else begin
                        code_q <= code_q + 1'b1;
                    end
                end
            end
        end
    end

    assign code_o = code_q;
    assign lock_o = lock_q;
    assign err_o  = err_q;
endmodule

// File: rtl/wlvl_cal.sv
// Write-leveling calibration controller top: synchronizes per-lane feedback,
// runs one shared sequencer and NUM_LANES independent lane searches.
// Assumes tap_limit_i and settle_i are held stable during a run.
module wlvl_cal #(
    parameter int NUM_LANES  = 2,
    parameter int CODE_W     = 6,
    parameter int SETTLE_W   = 8,
    parameter int VOTES      = 3,
    parameter int SAMPLE_LAT = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start_i,
    input  logic [NUM_LANES-1:0]          fb_i,
    input  logic [CODE_W-1:0]             tap_limit_i,
    input  logic [SETTLE_W-1:0]           settle_i,
    output logic                          pulse_o,
    output logic [NUM_LANES*CODE_W-1:0]   delay_o,
    output logic [NUM_LANES-1:0]          err_o,
    output logic                          done_o
);
    logic [NUM_LANES-1:0] fb_sync;
    logic [NUM_LANES-1:0] lock_w;
    logic                 clr;
    logic                 sample;
    logic                 decide;
    logic                 all_fin;

    assign all_fin = &(lock_w | err_o);

    wlvl_sync #(.WIDTH(NUM_LANES)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (fb_i),
        .q_o   (fb_sync)
    );

    wlvl_seq #(
        .SETTLE_W   (SETTLE_W),
        .VOTES      (VOTES),
        .SAMPLE_LAT (SAMPLE_LAT)
    ) i_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .all_fin_i (all_fin),
        .settle_i  (settle_i),
        .clr_o     (clr),
        .pulse_o   (pulse_o),
        .sample_o  (sample),
        .decide_o  (decide),
        .done_o    (done_o)
    );

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        wlvl_lane #(.CODE_W(CODE_W), .VOTES(VOTES)) i_lane (
            .clk         (clk),
            .rst_n       (rst_n),
            .clr_i       (clr),
            .sample_i    (sample),
            .decide_i    (decide),
            .fb_i        (fb_sync[g]),
            .tap_limit_i (tap_limit_i),
            .code_o      (delay_o[g*CODE_W +: CODE_W]),
            .lock_o      (lock_w[g]),
            .err_o       (err_o[g])
        );
    end
endmodule

// File: rtl/wlvl_cal_chk.sv
// Property checker for wlvl_cal, attached by bind.
// Assumes tap_limit_i and settle_i stay stable between an accepted start and done.
module wlvl_cal_chk #(
    parameter int NUM_LANES = 2,
    parameter int CODE_W    = 6,
    parameter int SETTLE_W  = 8
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        start_i,
    input logic                        pulse_o,
    input logic                        done_o,
    input logic [NUM_LANES*CODE_W-1:0] delay_o,
    input logic [NUM_LANES-1:0]        err_o,
    input logic [NUM_LANES-1:0]        lock_w,
    input logic [CODE_W-1:0]           tap_limit_i,
    input logic [SETTLE_W-1:0]         settle_i
);
    logic                        busy_q;
    logic [NUM_LANES*CODE_W-1:0] prev_q;
    logic [SETTLE_W:0]           gap_q;
    logic                        changed;

    assign changed = (delay_o != prev_q);

    // Track whether a run is in progress, as seen from the ports.
    always_ff @(posedge clk) begin
        if (!rst_n)        busy_q <= 1'b0;
        else if (done_o)   busy_q <= 1'b0;
        else if (start_i)  busy_q <= 1'b1;
    end

    // Count cycles since delay_o last changed, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '0;
            gap_q  <= '0;
        end else begin
            prev_q <= delay_o;
            if (changed)         gap_q <= '0;
            else if (!(&gap_q))  gap_q <= gap_q + 1'b1;
        end
    end

    a_r1_quiet_reset: assert property (@(posedge clk)
        !rst_n |=> (delay_o == '0 && err_o == '0 && !pulse_o && !done_o));

    a_r2_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_q) |=> (delay_o == '0 && err_o == '0));

    a_r9_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_o |=> !pulse_o);

    a_r9_settle_gap: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_o |-> (!changed && gap_q >= {1'b0, settle_i}));

    a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r10_done_all_fin: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (&(lock_w | err_o)));

    a_r10_no_pulse_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_q |-> !pulse_o);

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_chk
        a_r8_err_code_zero: assert property (@(posedge clk) disable iff (!rst_n)
            err_o[g] |-> (delay_o[g*CODE_W +: CODE_W] == '0));

        a_r8_within_limit: assert property (@(posedge clk) disable iff (!rst_n)
            busy_q |-> (delay_o[g*CODE_W +: CODE_W] <= tap_limit_i));

        a_r7_lock_holds: assert property (@(posedge clk) disable iff (!rst_n)
            (lock_w[g] && !start_i) |=> $stable(delay_o[g*CODE_W +: CODE_W]));

        a_r5_single_step: assert property (@(posedge clk) disable iff (!rst_n)
            (busy_q && !lock_w[g] && !err_o[g] && !start_i) |=>
                (err_o[g] || delay_o[g*CODE_W +: CODE_W] == $past(delay_o[g*CODE_W +: CODE_W])
                 || delay_o[g*CODE_W +: CODE_W] == $past(delay_o[g*CODE_W +: CODE_W]) + 1'b1));
    end
endmodule

bind wlvl_cal wlvl_cal_chk #(
    .NUM_LANES (NUM_LANES),
    .CODE_W    (CODE_W),
    .SETTLE_W  (SETTLE_W)
) i_wlvl_cal_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .pulse_o     (pulse_o),
    .done_o      (done_o),
    .delay_o     (delay_o),
    .err_o       (err_o),
    .lock_w      (lock_w),
    .tap_limit_i (tap_limit_i),
    .settle_i    (settle_i)
);

// File: tb/test_wlvl_cal.sv
// Directed bench for wlvl_cal with a threshold model of the memory feedback.
module test_wlvl_cal;
    localparam int NL = 2;
    localparam int CW = 6;
    localparam int SW = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic [NL-1:0]     fb_i = '0;
    logic [CW-1:0]     tap_limit_i = '0;
    logic [SW-1:0]     settle_i = '0;
    logic              pulse_o;
    logic [NL*CW-1:0]  delay_o;
    logic [NL-1:0]     err_o;
    logic              done_o;

    int checks = 0;
    int errors = 0;

    // Memory model: lane reports 1 when code < early or code >= thr.
    int thr   [NL];
    int early [NL];
    bit noise = 0;
    int glitch = 0;

    // Run monitors.
    int pulse_cnt = 0;
    int pulse_at_done = 0;
    int done_cnt = 0;
    int gap = 0;
    int min_gap = 1000;
    int pulse_run = 0;
    int max_pulse_run = 0;
    int snap = -1;
    logic [NL*CW-1:0] prev_delay = '0;
    int cycles = 0;

    wlvl_cal #(.NUM_LANES(NL), .CODE_W(CW), .SETTLE_W(SW)) i_wlvl_cal (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .fb_i        (fb_i),
        .tap_limit_i (tap_limit_i),
        .settle_i    (settle_i),
        .pulse_o     (pulse_o),
        .delay_o     (delay_o),
        .err_o       (err_o),
        .done_o      (done_o)
    );

    always #5 clk = ~clk;

    // Feedback model and monitors, all away from the active edge.
    always @(negedge clk) begin
        cycles++;
        if (glitch > 0) glitch--;
        if (pulse_o) begin
            if (noise && (pulse_cnt % 3 == 0)) glitch = 4;
            pulse_cnt++;
            pulse_run++;
            if (gap < min_gap) min_gap = gap;
        end else begin
            pulse_run = 0;
        end
        if (pulse_run > max_pulse_run) max_pulse_run = pulse_run;
        if (done_o) begin
            done_cnt++;
            pulse_at_done = pulse_cnt;
        end
        if (delay_o != prev_delay) gap = 0;
        else gap++;
        prev_delay = delay_o;
        if (snap < 0 && int'(delay_o[CW +: CW]) == 6) snap = int'(delay_o[0 +: CW]);
        for (int i = 0; i < NL; i++) begin
            int c;
            c = int'(delay_o[i*CW +: CW]);
            fb_i[i] <= ((c < early[i]) || (c >= thr[i])) ^ (glitch != 0);
        end
    end

    // Watchdog: a hung run is a failure and still reaches the summary.
    always @(negedge clk) begin
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected < 150000", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int lane(input int i);
        return int'(delay_o[i*CW +: CW]);
    endfunction

    // Configure the model, start a run, wait for done plus a quiet tail.
    task automatic run(input int lim, input int st, input int t0, input int e0,
                       input int t1, input int e1, input bit nz, input bit restart);
        @(negedge clk);
        tap_limit_i = CW'(lim);
        settle_i = SW'(st);
        thr[0] = t0; early[0] = e0;
        thr[1] = t1; early[1] = e1;
        noise = nz;
        pulse_cnt = 0; done_cnt = 0; min_gap = 1000; max_pulse_run = 0; snap = -1;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(delay_o == '0 && err_o == '0, "R2 start clears", int'(delay_o), 0);
        if (restart) begin
            repeat (40) @(negedge clk);
            start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
        end
        while (done_cnt == 0) @(negedge clk);
        repeat (60) @(negedge clk);
        noise = 0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(delay_o == '0 && err_o == '0 && !pulse_o && !done_o, "R1 in reset", int'(delay_o), 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk(delay_o == '0 && err_o == '0 && !pulse_o && !done_o, "R1 after reset", int'(delay_o), 0);
        chk(pulse_cnt == 0, "R1 no pulse before start", pulse_cnt, 0);
    endtask

    task automatic t_basic();
        run(20, 2, 3, 0, 9, 0, 0, 0);
        chk(lane(0) == 3, "R5 lane0 lock", lane(0), 3);
        chk(lane(1) == 9, "R3 lane1 independent lock", lane(1), 9);
        chk(err_o == '0, "R5 no error", int'(err_o), 0);
        chk(snap == 3, "R7 lane0 held while lane1 searches", snap, 3);
        chk(pulse_at_done == 30, "R4 three pulses per setting", pulse_at_done, 30);
        chk(done_cnt == 1, "R10 one done pulse", done_cnt, 1);
        chk(pulse_cnt == pulse_at_done, "R10 no pulse after done", pulse_cnt, pulse_at_done);
        chk(max_pulse_run == 1, "R9 pulse single cycle", max_pulse_run, 1);
    endtask

    task automatic t_early_one();
        run(20, 1, 5, 2, 0, 0, 0, 0);
        chk(lane(0) == 5, "R6 early one ignored", lane(0), 5);
        chk(err_o[0] == 1'b0, "R6 lane0 no error", int'(err_o[0]), 0);
        chk(err_o[1] == 1'b1, "R8 always-one lane fails", int'(err_o[1]), 1);
        chk(lane(1) == 0, "R8 failed lane code zero", lane(1), 0);
    endtask

    task automatic t_limit();
        run(7, 1, 7, 0, 8, 0, 0, 0);
        chk(lane(0) == 7 && !err_o[0], "R8 lock at tap limit", lane(0), 7);
        chk(err_o[1] == 1'b1 && lane(1) == 0, "R8 beyond limit fails", lane(1), 0);
        chk(done_cnt == 1, "R10 done after fail", done_cnt, 1);
    endtask

    task automatic t_noise();
        run(20, 1, 4, 0, 6, 0, 1, 0);
        chk(lane(0) == 4, "R4 noisy lane0 majority", lane(0), 4);
        chk(lane(1) == 6, "R4 noisy lane1 majority", lane(1), 6);
    endtask

    task automatic t_settle();
        run(20, 9, 2, 0, 4, 0, 0, 0);
        chk(min_gap >= 9, "R9 settle gap", min_gap, 9);
        chk(lane(0) == 2 && lane(1) == 4, "R9 result with long settle", lane(1), 4);
    endtask

    task automatic t_restart_ignored();
        run(20, 1, 3, 0, 6, 0, 0, 1);
        chk(done_cnt == 1, "R2 restart ignored one done", done_cnt, 1);
        chk(pulse_at_done == 21, "R2 restart ignored pulse count", pulse_at_done, 21);
        chk(lane(0) == 3 && lane(1) == 6, "R2 restart ignored result", lane(1), 6);
    endtask

    initial begin
        thr[0] = 63; thr[1] = 63; early[0] = 0; early[1] = 0;
        t_reset();
        t_basic();
        t_early_one();
        t_limit();
        t_noise();
        t_settle();
        t_restart_ignored();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule